// File: doc/BRIEF.md
# CCD Pixel Region Tagger and Black-Level Corrector

This block sits behind the readout sequencer and ADC of a full-frame CCD camera. It takes one digitised sample per valid cycle, together with a start-of-frame and a start-of-line marker, and works out where that sample sits in the sensor's border geometry. Each sample is classed as dummy shift count, light-shielded dark reference, light-sensitive buffer, active image or overclock.

On every line, a window of the leading shielded columns is summed. That sum gives a per-line black level. The window leaves out the dummy counts and the first shielded columns next to them. Active samples leave the block with this level subtracted, clamped at zero. Every other class leaves with a zero data word, but it keeps its tag. A frame-level sum of the shielded top rows is published once per frame on a side output.

All border sizes are parameters. The defaults describe a 4641-count by 3695-row readout with a 4500 by 3600 active area. Smaller geometries can be chosen so that a full frame stays short in simulation.

Top module: `ccd_region_tagger`

## Requirements
- R1: The column index restarts at 0 on a sample that carries `pix_sol` or `pix_sof`. Columns are classed left to right: the first `N_DUMMY` are dummy (tag 0), the next `N_DARK` are dark (tag 1), the next `N_BUF` are buffer (tag 2), the next `N_ACT_COLS` are active (tag 3) and the next `N_BUF` are buffer (tag 2). The columns that remain up to `N_COLS` are dark (tag 1).
- R2: The row index restarts at 0 with `pix_sof` and advances on each `pix_sol`. Rows below `N_DARK_TOP` and the last `N_DARK_BOT` rows are dark. The `N_ACT_ROWS` rows that start after `N_BUF_ROWS` buffer rows are active. All other rows are buffer. The final tag follows this priority: overclock, then dummy column, then dark (by row or by column), then buffer (by row or by column), then active.
- R3: A sample at column `N_COLS` or beyond, or at row `N_ROWS` or beyond, is tagged overclock (tag 4). Samples after reset and before the first `pix_sof` are also overclock.
- R4: A cycle with `pix_valid` low does not move the position. `out_valid` equals `pix_valid` one cycle later, and `out_tag`/`out_pix` describe that sample.
- R5: The line black level is the sum of the `2**LOG2_AVG` dark columns that start `N_DARK_SKIP` columns after the dummy columns, shifted right by `LOG2_AVG`. Dummy values and skipped dark values have no effect on it.
- R6: For an active sample, `out_pix` is the raw value minus the current line's black level, or 0 when the black level is greater than or equal to the raw value.
- R7: For every non-active tag, `out_pix` is 0.
- R8: The block sums the samples in rows below `N_DARK_TOP` that fall in the active column span, from `pix_sof` onwards. At the sample at row `N_ROWS-1`, column `N_COLS-1`, `frame_stb` pulses for one cycle and `frame_sum` takes the total. At all other times `frame_sum` holds its value.
- R9: While `rst_n` is low, and in the cycle after it rises, `out_valid`, `out_tag`, `out_pix`, `frame_stb` and `frame_sum` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Sample present this cycle |
| pix_sof | input | 1 | Sample is the first of a frame (implies line start) |
| pix_sol | input | 1 | Sample is the first of a line |
| pix_data | input | DW | Raw ADC sample |
| out_valid | output | 1 | Output sample present |
| out_tag | output | 3 | Region: 0 dummy, 1 dark, 2 buffer, 3 active, 4 overclock |
| out_pix | output | DW | Black-corrected active value, 0 otherwise |
| frame_stb | output | 1 | One-cycle pulse when a frame's dark sum is published |
| frame_sum | output | SW | Sum of top dark rows over the active column span |

## Verification
The bound checker watches several behaviours on every cycle. It checks that valid passes through with a one-cycle delay. It checks that non-active samples carry zero data and that a corrected value never exceeds the raw sample it came from. It checks that a frame start yields a dummy tag, that the frame strobe lasts one cycle, and that the frame sum holds between strobes. Other behaviours can only be shown by the bench's scenarios, because they depend on whole lines of stimulus. These are the exact tag for each row and column, the window average with its skipped and dummy columns, the saturation values, the overclock tails, the effect of idle gaps, and a frame start that cuts a frame short.

// File: rtl/ccdtag_pkg.sv
`timescale 1ns/1ps
// Shared types for the pixel region tagger.
// Assumes: tag codes are fixed because downstream logic decodes them.
package ccdtag_pkg;
    typedef enum logic [2:0] {
        TAG_DUMMY   = 3'd0,
        TAG_DARK    = 3'd1,
        TAG_BUFFER  = 3'd2,
        TAG_ACTIVE  = 3'd3,
        TAG_OVERCLK = 3'd4
    } region_t;
endpackage

// File: rtl/ccdtag_locator.sv
`timescale 1ns/1ps
// Tracks the row and column of each incoming sample and classes it by region.
// Outputs describe the sample presented this cycle (combinational).
// Assumes: sof implies a line start; counters saturate at the overclock limit.
module ccdtag_locator
    import ccdtag_pkg::*;
#(
    parameter int N_DUMMY     = 20,
    parameter int N_DARK      = 36,
    parameter int N_DARK_SKIP = 4,
    parameter int N_BUF       = 20,
    parameter int N_ACT_COLS  = 4500,
    parameter int N_COLS      = 4641,
    parameter int N_DARK_TOP  = 30,
    parameter int N_DARK_BOT  = 23,
    parameter int N_BUF_ROWS  = 20,
    parameter int N_ACT_ROWS  = 3600,
    parameter int N_ROWS      = 3695
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  logic    in_sof,
    input  logic    in_sol,
    output region_t tag,
    output logic    in_win,
    output logic    win_last,
    output logic    in_top_span,
    output logic    frame_last
);
    localparam int CW = $clog2(N_COLS + 1);
    localparam int RW = $clog2(N_ROWS + 1);
    localparam logic [CW-1:0] C_DARK0 = CW'(N_DUMMY);
    localparam logic [CW-1:0] C_WIN0  = CW'(N_DUMMY + N_DARK_SKIP);
    localparam logic [CW-1:0] C_BUF0  = CW'(N_DUMMY + N_DARK);
    localparam logic [CW-1:0] C_ACT0  = CW'(N_DUMMY + N_DARK + N_BUF);
    localparam logic [CW-1:0] C_ACT1  = CW'(N_DUMMY + N_DARK + N_BUF + N_ACT_COLS);
    localparam logic [CW-1:0] C_TBUF1 = CW'(N_DUMMY + N_DARK + 2 * N_BUF + N_ACT_COLS);
    localparam logic [CW-1:0] C_END   = CW'(N_COLS);
    localparam logic [CW-1:0] C_LAST  = CW'(N_COLS - 1);
    localparam logic [CW-1:0] C_WLAST = CW'(N_DUMMY + N_DARK - 1);
    localparam logic [RW-1:0] R_BUF0  = RW'(N_DARK_TOP);
    localparam logic [RW-1:0] R_ACT0  = RW'(N_DARK_TOP + N_BUF_ROWS);
    localparam logic [RW-1:0] R_ACT1  = RW'(N_DARK_TOP + N_BUF_ROWS + N_ACT_ROWS);
    localparam logic [RW-1:0] R_DBOT  = RW'(N_ROWS - N_DARK_BOT);
    localparam logic [RW-1:0] R_END   = RW'(N_ROWS);
    localparam logic [RW-1:0] R_LAST  = RW'(N_ROWS - 1);

    logic [CW-1:0] col_nxt, cur_col;
    logic [RW-1:0] row_q, cur_row;
    region_t       col_cls, row_cls;

    // Position of the sample presented this cycle.
    always_comb begin
        cur_col = (in_sol || in_sof) ? '0 : col_nxt;
        if (in_sof)      cur_row = '0;
        else if (in_sol) cur_row = (row_q == R_END) ? R_END : row_q + 1'b1;
        else             cur_row = row_q;
    end

    // Advance the position on each valid sample; park in overclock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_nxt <= C_END;
            row_q   <= R_END;
        end else if (in_valid) begin
            col_nxt <= (cur_col == C_END) ? C_END : cur_col + 1'b1;
            row_q   <= cur_row;
        end
    end

    // Class of the current column.
    always_comb begin
        if (cur_col >= C_END)        col_cls = TAG_OVERCLK;
        else if (cur_col < C_DARK0)  col_cls = TAG_DUMMY;
        else if (cur_col < C_BUF0)   col_cls = TAG_DARK;
        else if (cur_col < C_ACT0)   col_cls = TAG_BUFFER;
        else if (cur_col < C_ACT1)   col_cls = TAG_ACTIVE;
        else if (cur_col < C_TBUF1)  col_cls = TAG_BUFFER;
        else                         col_cls = TAG_DARK;
    end

    // Class of the current row.
    always_comb begin
        if (cur_row >= R_END)                           row_cls = TAG_OVERCLK;
        else if (cur_row < R_BUF0 || cur_row >= R_DBOT) row_cls = TAG_DARK;
        else if (cur_row >= R_ACT0 && cur_row < R_ACT1) row_cls = TAG_ACTIVE;
        else                                            row_cls = TAG_BUFFER;
    end

    // Merge row and column classes by priority.
    always_comb begin
        if (col_cls == TAG_OVERCLK || row_cls == TAG_OVERCLK)   tag = TAG_OVERCLK;
        else if (col_cls == TAG_DUMMY)                          tag = TAG_DUMMY;
        else if (col_cls == TAG_DARK || row_cls == TAG_DARK)     tag = TAG_DARK;
        else if (col_cls == TAG_BUFFER || row_cls == TAG_BUFFER) tag = TAG_BUFFER;
        else                                                    tag = TAG_ACTIVE;
    end

    // Window and frame markers used by the accumulators.
    always_comb begin
        in_win      = (cur_col >= C_WIN0) && (cur_col < C_BUF0);
        win_last    = (cur_col == C_WLAST);
        in_top_span = (cur_row < R_BUF0) && (cur_col >= C_ACT0) && (cur_col < C_ACT1);
        frame_last  = (cur_row == R_LAST) && (cur_col == C_LAST);
    end
endmodule

// File: rtl/ccdtag_line_black.sv
`timescale 1ns/1ps
// Sums the dark-reference window of one line and latches its average.
// Assumes: the window holds exactly 2**LOG2_AVG samples and ends before
// the first active column; acc_last marks the window's final sample.
module ccdtag_line_black #(
    parameter int DW       = 12,
    parameter int LOG2_AVG = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_last,
    input  logic          acc_clr,
    input  logic [DW-1:0] pix,
    output logic [DW-1:0] black
);
    localparam int AW = DW + LOG2_AVG;

    logic [AW-1:0] acc, acc_sum;

    // Running sum including the present sample.
    always_comb acc_sum = acc + AW'(pix);

    // Accumulate the window, publish the average at its last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            black <= '0;
        end else if (acc_en && acc_last) begin
            acc   <= '0;
            black <= acc_sum[AW-1:LOG2_AVG];
        end else if (acc_en) begin
            acc   <= acc_sum;
        end else if (acc_clr) begin
            acc   <= '0;
        end
    end
endmodule

// File: rtl/ccdtag_frame_stat.sv
`timescale 1ns/1ps
// Sums the shielded top-row samples of a frame and publishes the sum once.
// Assumes: a frame start clears the running sum; frame_last is one sample.
module ccdtag_frame_stat #(
    parameter int DW = 12,
    parameter int SW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic          frame_first,
    input  logic          frame_last,
    input  logic [DW-1:0] pix,
    output logic [SW-1:0] sum,
    output logic          stb
);
    logic [SW-1:0] acc, addend;

    // Contribution of the present sample.
    always_comb addend = add_en ? SW'(pix) : '0;

    // Accumulate over the frame and latch at its final sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            sum <= '0;
            stb <= 1'b0;
        end else begin
            stb <= frame_last;
            if (frame_first)     acc <= addend;
            else                 acc <= acc + addend;
            if (frame_last)      sum <= (frame_first ? '0 : acc) + addend;
        end
    end
endmodule

// File: rtl/ccd_region_tagger.sv
`timescale 1ns/1ps
// Top: tags each CCD sample by region, subtracts the per-line black level
// from active samples (clamped at zero) and reports a frame dark sum.
// Assumes: N_DARK - N_DARK_SKIP == 2**LOG2_AVG, N_DUMMY + N_DARK_SKIP > 0,
// and the border sizes fit inside N_COLS / N_ROWS.
module ccd_region_tagger
    import ccdtag_pkg::*;
#(
    parameter int DW          = 12,
    parameter int N_DUMMY     = 20,
    parameter int N_DARK      = 36,
    parameter int N_DARK_SKIP = 4,
    parameter int LOG2_AVG    = 5,
    parameter int N_BUF       = 20,
    parameter int N_ACT_COLS  = 4500,
    parameter int N_COLS      = 4641,
    parameter int N_DARK_TOP  = 30,
    parameter int N_DARK_BOT  = 23,
    parameter int N_BUF_ROWS  = 20,
    parameter int N_ACT_ROWS  = 3600,
    parameter int N_ROWS      = 3695,
    localparam int SW         = DW + $clog2(N_DARK_TOP * N_ACT_COLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          pix_sof,
    input  logic          pix_sol,
    input  logic [DW-1:0] pix_data,
    output logic          out_valid,
    output logic [2:0]    out_tag,
    output logic [DW-1:0] out_pix,
    output logic          frame_stb,
    output logic [SW-1:0] frame_sum
);
    region_t       tag;
    logic          in_win, win_last, in_top_span, frame_last;
    logic [DW-1:0] black, corr;
    logic [DW:0]   diff;

    ccdtag_locator #(
        .N_DUMMY(N_DUMMY), .N_DARK(N_DARK), .N_DARK_SKIP(N_DARK_SKIP),
        .N_BUF(N_BUF), .N_ACT_COLS(N_ACT_COLS), .N_COLS(N_COLS),
        .N_DARK_TOP(N_DARK_TOP), .N_DARK_BOT(N_DARK_BOT),
        .N_BUF_ROWS(N_BUF_ROWS), .N_ACT_ROWS(N_ACT_ROWS), .N_ROWS(N_ROWS)
    ) u_loc (
        .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_sof(pix_sof),
        .in_sol(pix_sol), .tag(tag), .in_win(in_win), .win_last(win_last),
        .in_top_span(in_top_span), .frame_last(frame_last)
    );

    ccdtag_line_black #(.DW(DW), .LOG2_AVG(LOG2_AVG)) u_blk (
        .clk(clk), .rst_n(rst_n),
        .acc_en(pix_valid && in_win && tag != TAG_OVERCLK),
        .acc_last(win_last),
        .acc_clr(pix_valid && (pix_sol || pix_sof)),
        .pix(pix_data), .black(black)
    );

    ccdtag_frame_stat #(.DW(DW), .SW(SW)) u_frm (
        .clk(clk), .rst_n(rst_n),
        .add_en(pix_valid && in_top_span),
        .frame_first(pix_valid && pix_sof),
        .frame_last(pix_valid && frame_last),
        .pix(pix_data), .sum(frame_sum), .stb(frame_stb)
    );

    // Black-corrected value, clamped at zero.
    always_comb begin
        diff = {1'b0, pix_data} - {1'b0, black};
        corr = diff[DW] ? '0 : diff[DW-1:0];
    end

    // Register the tagged, corrected output stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= 3'd0;
            out_pix   <= '0;
        end else begin
            out_valid <= pix_valid;
            out_tag   <= tag;
            out_pix   <= (tag == TAG_ACTIVE) ? corr : '0;
        end
    end
endmodule

// File: rtl/ccd_region_tagger_chk.sv
`timescale 1ns/1ps
// Cycle-level checker for ccd_region_tagger, attached by bind below.
// Assumes: frames are longer than one sample.
module ccd_region_tagger_chk
    import ccdtag_pkg::*;
#(
    parameter int DW      = 12,
    parameter int SW      = 30,
    parameter int N_DUMMY = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid,
    input logic          pix_sof,
    input logic [DW-1:0] pix_data,
    input logic          out_valid,
    input logic [2:0]    out_tag,
    input logic [DW-1:0] out_pix,
    input logic          frame_stb,
    input logic [SW-1:0] frame_sum
);
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    a_r4_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);
    a_r7_nonactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag != TAG_ACTIVE) |-> out_pix == '0);
    a_r6_not_above_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == TAG_ACTIVE) |-> out_pix <= $past(pix_data));
    a_r1_sof_is_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sof && N_DUMMY > 0) |=> out_tag == TAG_DUMMY);
    a_r3_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag <= TAG_OVERCLK);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);
    a_r8_sum_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && $past(rst_n)) |-> $stable(frame_sum));
endmodule

bind ccd_region_tagger ccd_region_tagger_chk #(.DW(DW), .SW(SW), .N_DUMMY(N_DUMMY)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_data(pix_data), .out_valid(out_valid), .out_tag(out_tag),
    .out_pix(out_pix), .frame_stb(frame_stb), .frame_sum(frame_sum)
);

// File: tb/test_ccd_region_tagger.sv
`timescale 1ns/1ps
// Bench: small geometry, table-driven frames plus directed corner cases.
module test_ccd_region_tagger;
    localparam int DW = 12, N_DUMMY = 2, N_DARK = 6, N_DARK_SKIP = 2, LOG2_AVG = 2;
    localparam int N_BUF = 1, N_ACT_COLS = 3, N_COLS = 15;
    localparam int N_DARK_TOP = 2, N_DARK_BOT = 1, N_BUF_ROWS = 1, N_ACT_ROWS = 3, N_ROWS = 9;
    localparam int SW = DW + $clog2(N_DARK_TOP * N_ACT_COLS + 1);
    localparam int ACT0 = N_DUMMY + N_DARK + N_BUF;
    localparam int WIN0 = N_DUMMY + N_DARK_SKIP;

    // {dark base, active raw, expected corrected}
    localparam logic [35:0] TAB [8] = '{
        {12'd100,  12'd150,  12'd50},
        {12'd200,  12'd50,   12'd0},
        {12'd300,  12'd300,  12'd0},
        {12'd0,    12'd4095, 12'd4095},
        {12'd4095, 12'd4095, 12'd0},
        {12'd17,   12'd18,   12'd1},
        {12'd1000, 12'd999,  12'd0},
        {12'd5,    12'd6,    12'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_sof = 1'b0, pix_sol = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic out_valid, frame_stb;
    logic [2:0] out_tag;
    logic [DW-1:0] out_pix;
    logic [SW-1:0] frame_sum;
    int n_chk = 0, n_fail = 0;
    longint last_sum = 0;

    always #2.5 clk = ~clk;

    ccd_region_tagger #(
        .DW(DW), .N_DUMMY(N_DUMMY), .N_DARK(N_DARK), .N_DARK_SKIP(N_DARK_SKIP),
        .LOG2_AVG(LOG2_AVG), .N_BUF(N_BUF), .N_ACT_COLS(N_ACT_COLS), .N_COLS(N_COLS),
        .N_DARK_TOP(N_DARK_TOP), .N_DARK_BOT(N_DARK_BOT), .N_BUF_ROWS(N_BUF_ROWS),
        .N_ACT_ROWS(N_ACT_ROWS), .N_ROWS(N_ROWS)
    ) i_ccd_region_tagger (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_sol(pix_sol), .pix_data(pix_data), .out_valid(out_valid),
        .out_tag(out_tag), .out_pix(out_pix), .frame_stb(frame_stb),
        .frame_sum(frame_sum)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected region from R1, R2 and R3.
    function automatic int tag_m(input int r, input int c);
        int cc, rc;
        if (c >= N_COLS || r >= N_ROWS) return 4;
        if (c < N_DUMMY) cc = 0;
        else if (c < N_DUMMY + N_DARK) cc = 1;
        else if (c < ACT0) cc = 2;
        else if (c < ACT0 + N_ACT_COLS) cc = 3;
        else if (c < ACT0 + N_ACT_COLS + N_BUF) cc = 2;
        else cc = 1;
        if (r < N_DARK_TOP || r >= N_ROWS - N_DARK_BOT) rc = 1;
        else if (r >= N_DARK_TOP + N_BUF_ROWS && r < N_DARK_TOP + N_BUF_ROWS + N_ACT_ROWS) rc = 3;
        else rc = 2;
        if (cc == 0) return 0;
        if (cc == 1 || rc == 1) return 1;
        if (cc == 2 || rc == 2) return 2;
        return 3;
    endfunction

    // Stimulus value per position; mode 1 uses an uneven dark window.
    function automatic int pv(input int mode, input int ent, input int c);
        if (c >= N_COLS) return 1234;
        if (c < N_DUMMY) return 4095 - c;
        if (c < WIN0) return 4000;
        if (c < N_DUMMY + N_DARK) begin
            if (mode == 1) return 10 + (c - WIN0) + ((c - WIN0) == 3 ? 1 : 0);
            return int'(TAB[ent][35:24]);
        end
        if (c >= ACT0 && c < ACT0 + N_ACT_COLS)
            return (mode == 1) ? 20 : int'(TAB[ent][23:12]);
        if (c < ACT0 + N_ACT_COLS + N_BUF) return 3000;
        return 2222;
    endfunction

    task automatic step(input logic v, input logic sf, input logic sl, input int d,
                        input int etag, input int epix, input logic estb, input longint esum,
                        input string treq);
        @(negedge clk);
        pix_valid = v; pix_sof = sf; pix_sol = sl; pix_data = DW'(d);
        @(posedge clk);
        #1;
        chk("R4 out_valid", longint'(out_valid), longint'(v));
        chk("R8 frame_stb", longint'(frame_stb), longint'(estb));
        if (v) begin
            chk(treq, longint'(out_tag), longint'(etag));
            chk(etag == 3 ? "R6 corrected" : "R7 non-active zero", longint'(out_pix), longint'(epix));
        end
        if (estb) chk("R8 frame_sum", longint'(frame_sum), esum);
    endtask

    // Stream one frame; checks every sample against the model.
    task automatic run_frame(input int mode, input int off, input int xc, input int nrows, input bit gaps);
        longint fsum = 0;
        for (int r = 0; r < nrows; r++) begin
            int ent = (r + off) % 8;
            for (int c = 0; c < N_COLS + xc; c++) begin
                int t = tag_m(r, c);
                int d = pv(mode, ent, c);
                int e = (t != 3) ? 0 : (mode == 1 ? 9 : int'(TAB[ent][11:0]));
                bit last = (r == N_ROWS - 1) && (c == N_COLS - 1);
                if (gaps && (c % 4 == 1)) step(1'b0, 1'b0, 1'b0, 77, 0, 0, 1'b0, 0, "R4 gap");
                if (r < N_DARK_TOP && c >= ACT0 && c < ACT0 + N_ACT_COLS) fsum += d;
                step(1'b1, (r == 0 && c == 0), (c == 0), d, t, e, last, fsum, "R1/R2/R3 tag");
                if (last) last_sum = fsum;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R9 out_valid", longint'(out_valid), 0);
        chk("R9 out_tag", longint'(out_tag), 0);
        chk("R9 out_pix", longint'(out_pix), 0);
        chk("R9 frame_stb", longint'(frame_stb), 0);
        chk("R9 frame_sum", longint'(frame_sum), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R9 after release", longint'(out_valid), 0);

        // R3: samples before any frame start are overclock
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 500, 4, 0, 1'b0, 0, "R3 pre-frame");

        // Table walk: each offset puts different table rows into the active rows
        for (int k = 0; k < 3; k++) run_frame(0, k * 5 % 8 == 0 ? 0 : (k == 1 ? 5 : 3), 0, N_ROWS, 1'b0);

        // R5/R3/R4: uneven window, overclock tails, idle gaps
        run_frame(1, 0, 2, N_ROWS + 1, 1'b1);

        // R8: frame cut short by a new start keeps the old sum
        run_frame(0, 0, 0, 4, 1'b0);
        chk("R8 sum held after cut frame", longint'(frame_sum), last_sum);
        run_frame(0, 0, 0, N_ROWS, 1'b0);

        // R9: reset mid-line, then markerless samples are overclock again
        @(negedge clk); pix_valid = 1'b1; pix_sof = 1'b1; pix_sol = 1'b1; pix_data = 12'd9;
        @(negedge clk); rst_n = 1'b0; pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0;
        @(posedge clk); #1;
        chk("R9 mid-stream out_valid", longint'(out_valid), 0);
        chk("R9 mid-stream frame_sum", longint'(frame_sum), 0);
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0, 42, 4, 0, 1'b0, 0, "R3 after reset");
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, "R4 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule